// File: doc/BRIEF.md
# Prescaled Watchdog With Feed Lock

This block is a watchdog timer for a small microcontroller. A down-counter is advanced by ticks from a power-of-two prescaler running on the oscillator clock. Software reaches a control register and a reload register through a simple register write port, and keeps the watchdog alive by writing a two-byte unlock pattern to a separate feed port. A valid feed reloads the counter and clears the prescaler.

Control writes are locked: they land in a shadow copy and reach the active control register only when a valid feed arrives, or as the first control write after a valid feed. The block leaves reset already armed with a short fixed timeout. It can only be disarmed by feeding it and then writing the run bit low. In watchdog mode an expiry pulses a chip reset request and sets a sticky timeout flag. In timer mode an expiry only sets the flag, and the run bit can be switched freely.

Top module: `prescaled_wdt`

## Requirements
- R1: While reset is held, ctrl_o reads 0x25, count_o reads 255, and tmo_flag_o and wdt_rst_o are low. The ctrl_o bit layout is [7:5] prescale select, [4] low-voltage reset enable, [3] clock-fail reset enable, [2] run, [1] power-down disable, and [0] mode, where 1 means watchdog and 0 means timer.
- R2: While running, expiry occurs exactly (reload+1)·2^(sel+5) clock edges after a valid feed, or after reset release. Here sel is ctrl_o[7:5] and reload is the reload register. The default after reset is 16384 edges.
- R3: In watchdog mode an expiry drives wdt_rst_o high for exactly one cycle and sets tmo_flag_o in the same cycle.
- R4: In timer mode an expiry sets tmo_flag_o and leaves wdt_rst_o low.
- R5: tmo_flag_o stays set until a cycle with flag_clr_i high and no new expiry.
- R6: A control write (reg_we_i=1, reg_sel_i=0) made in watchdog mode outside the unlock window does not change ctrl_o. The written value is held in a shadow copy.
- R7: A valid feed is a feed-port write of 0xA5 whose next feed-port write is 0x5A. Idle cycles between the two are allowed. Any other byte aborts the pattern, and a repeated 0xA5 restarts it.
- R8: A valid feed copies the shadow into ctrl_o, loads the counter from the reload register (reg_sel_i=1), and clears the prescaler.
- R9: The first control write after a valid feed is applied directly to ctrl_o. This is how the run bit is cleared to disarm the watchdog.
- R10: With the run bit low, count_o and the prescaler hold, and no expiry occurs.
- R11: In timer mode a control write changes the run bit of ctrl_o at once and leaves its other bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 1 | 0 selects control, 1 selects reload |
| reg_wdata_i | input | 8 | Register write data |
| feed_we_i | input | 1 | Feed port write strobe |
| feed_data_i | input | 8 | Feed byte |
| flag_clr_i | input | 1 | Clear the timeout flag |
| ctrl_o | output | 8 | Active control register |
| count_o | output | 8 | Current counter value |
| tmo_flag_o | output | 1 | Sticky timeout flag |
| wdt_rst_o | output | 1 | One-cycle chip reset request |

## Verification
The assertions watch four things on every cycle. They check that the reset request is a single cycle and always comes with the flag, and that it never follows a cycle in timer mode. They check that the flag is sticky, that ctrl_o moves only on a control write or a feed-port write, and that the counter freezes while the run bit is low. The exact expiry count for each prescale and reload setting can only be shown by the bench's timed scenarios. The same goes for the shadow lock and the unlock window, abort versus restart of the feed pattern, and the run-bit-only update in timer mode.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned SEL_W = 3;
  localparam logic [7:0] FEED_FIRST  = 8'hA5;
  localparam logic [7:0] FEED_SECOND = 8'h5A;
  localparam logic REG_CTRL   = 1'b0;
  localparam logic REG_RELOAD = 1'b1;

  typedef struct packed {
    logic [SEL_W-1:0] pre_sel;
    logic             lvr_en;
    logic             clkf_en;
    logic             run;
    logic             pd_dis;
    logic             wd_mode;
  } ctrl_t;
endpackage

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq
  import wdt_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       feed_we_i,
  input  logic [7:0] feed_data_i,
  output logic       feed_ok_o
);
  logic armed_q;

  assign feed_ok_o = feed_we_i && armed_q && (feed_data_i == FEED_SECOND);

  // every feed write re-evaluates the pattern; a first byte (re)arms
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        armed_q <= 1'b0;
    else if (feed_we_i) armed_q <= (feed_data_i == FEED_FIRST);
  end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int unsigned PRE_BASE = 5,
  localparam int unsigned PRE_W = PRE_BASE + (1 << SEL_W) - 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q;
  logic [PRE_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) mask[i] = (i < (PRE_BASE + int'(sel_i)));
    tick_o = run_i && (&(cnt_q | ~mask));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (run_i) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W = 8,
  parameter logic [CNT_W-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  logic [CNT_W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  assign ovf_o = tick_i && !load_i && (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= RST_VAL;
    else if (load_i) cnt_q <= load_val_i;
    else if (tick_i) cnt_q <= (cnt_q == '0) ? load_val_i : cnt_q - 1'b1;
  end
endmodule

// File: rtl/prescaled_wdt.sv
module prescaled_wdt
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_BASE = 5,
  parameter logic [SEL_W-1:0] RST_SEL = 3'd1,
  parameter logic [CNT_W-1:0] RST_RELOAD = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             reg_we_i,
  input  logic             reg_sel_i,
  input  logic [7:0]       reg_wdata_i,
  input  logic             feed_we_i,
  input  logic [7:0]       feed_data_i,
  input  logic             flag_clr_i,
  output logic [7:0]       ctrl_o,
  output logic [CNT_W-1:0] count_o,
  output logic             tmo_flag_o,
  output logic             wdt_rst_o
);
  localparam ctrl_t CTRL_RST = '{pre_sel: RST_SEL, lvr_en: 1'b0, clkf_en: 1'b0,
                                 run: 1'b1, pd_dis: 1'b0, wd_mode: 1'b1};

  ctrl_t            ctrl_q, shadow_q, wr_ctrl;
  logic [CNT_W-1:0] reload_q;
  logic             unlock_q, flag_q, rst_q;
  logic             feed_ok, tick, ovf, ctrl_wr, reload_wr;

  assign wr_ctrl   = ctrl_t'(reg_wdata_i);
  assign ctrl_wr   = reg_we_i && (reg_sel_i == REG_CTRL);
  assign reload_wr = reg_we_i && (reg_sel_i == REG_RELOAD);

  wdt_feed_seq i_feed (
    .clk_i, .rst_ni, .feed_we_i, .feed_data_i, .feed_ok_o(feed_ok)
  );

  wdt_prescaler #(.PRE_BASE(PRE_BASE)) i_pre (
    .clk_i, .rst_ni, .run_i(ctrl_q.run), .clr_i(feed_ok),
    .sel_i(ctrl_q.pre_sel), .tick_o(tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .RST_VAL(RST_RELOAD)) i_cnt (
    .clk_i, .rst_ni, .tick_i(tick), .load_i(feed_ok),
    .load_val_i(reload_q), .cnt_o(count_o), .ovf_o(ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q   <= CTRL_RST;
      shadow_q <= CTRL_RST;
      reload_q <= RST_RELOAD;
      unlock_q <= 1'b0;
    end else begin
      if (reload_wr) reload_q <= reg_wdata_i[CNT_W-1:0];
      if (ctrl_wr)   shadow_q <= wr_ctrl;
      if (feed_ok)      unlock_q <= 1'b1;
      else if (ctrl_wr) unlock_q <= 1'b0;
      // feed applies shadow; unlock window passes one write; timer mode passes run only
      if (feed_ok)                          ctrl_q     <= shadow_q;
      else if (ctrl_wr && unlock_q)         ctrl_q     <= wr_ctrl;
      else if (ctrl_wr && !ctrl_q.wd_mode)  ctrl_q.run <= wr_ctrl.run;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      rst_q  <= 1'b0;
    end else begin
      if (ovf)             flag_q <= 1'b1;
      else if (flag_clr_i) flag_q <= 1'b0;
      rst_q <= ovf && ctrl_q.wd_mode;
    end
  end

  assign ctrl_o     = ctrl_q;
  assign tmo_flag_o = flag_q;
  assign wdt_rst_o  = rst_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic             reg_sel_i,
  input logic             feed_we_i,
  input logic             flag_clr_i,
  input logic [7:0]       ctrl_o,
  input logic [CNT_W-1:0] count_o,
  input logic             tmo_flag_o,
  input logic             wdt_rst_o
);
  a_r3_rst_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);

  a_r3_rst_with_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> tmo_flag_o);

  a_r4_no_rst_in_timer: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> $past(ctrl_o[0]));

  a_r5_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tmo_flag_o && !flag_clr_i) |=> tmo_flag_o);

  a_r6_ctrl_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!feed_we_i && !(reg_we_i && !reg_sel_i)) |=> $stable(ctrl_o));

  a_r10_hold_when_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl_o[2] && !feed_we_i) |=> $stable(count_o));
endmodule

bind prescaled_wdt wdt_checker #(.CNT_W(CNT_W)) i_wdt_checker (
  .clk_i(clk_i), .rst_ni(rst_ni), .reg_we_i(reg_we_i), .reg_sel_i(reg_sel_i),
  .feed_we_i(feed_we_i), .flag_clr_i(flag_clr_i), .ctrl_o(ctrl_o),
  .count_o(count_o), .tmo_flag_o(tmo_flag_o), .wdt_rst_o(wdt_rst_o)
);

// File: tb/test_prescaled_wdt.sv
module test_prescaled_wdt;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       reg_we_i = 1'b0, reg_sel_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic       feed_we_i = 1'b0;
  logic [7:0] feed_data_i = '0;
  logic       flag_clr_i = 1'b0;
  logic [7:0] ctrl_o, count_o;
  logic       tmo_flag_o, wdt_rst_o;

  int n_chk = 0, n_fail = 0, rst_seen = 0;
  bit done = 1'b0;

  prescaled_wdt i_prescaled_wdt (.*);

  always #5 clk_i = ~clk_i;

  always @(negedge clk_i) if (rst_ni && wdt_rst_o) rst_seen++;

  function automatic int exp_tmo(input int sel, input int reload);
    return (reload + 1) << (sel + 5);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic sel, input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_sel_i = sel; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic feed_byte(input logic [7:0] d, input bit clr);
    @(negedge clk_i);
    feed_we_i = 1'b1; feed_data_i = d; flag_clr_i = clr;
    @(negedge clk_i);
    feed_we_i = 1'b0; flag_clr_i = 1'b0;
  endtask

  task automatic feed(input bit clr);
    feed_byte(8'hA5, 1'b0);
    feed_byte(8'h5A, clr);
  endtask

  task automatic clear_flag();
    @(negedge clk_i);
    flag_clr_i = 1'b1;
    @(negedge clk_i);
    flag_clr_i = 1'b0;
  endtask

  // counts edges from the current negedge until the chosen output is seen high
  task automatic wait_expiry(input bit use_rst, output int n);
    n = 0;
    do begin
      @(posedge clk_i); n++;
      @(negedge clk_i);
    end while (!(use_rst ? wdt_rst_o : tmo_flag_o) && n < 40000);
  endtask

  initial begin
    int n, sel, rl, snap, rs;
    logic [7:0] c;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(ctrl_o == 8'h25, "R1 ctrl", ctrl_o, 8'h25);
    check(count_o == 8'd255, "R1 count", count_o, 255);
    check(!tmo_flag_o && !wdt_rst_o, "R1 flag/rst", {tmo_flag_o, wdt_rst_o}, 0);
    rst_ni = 1'b1;

    // R2 default timeout, R3 pulse
    wait_expiry(1'b1, n);
    check(n == 16384, "R2 default timeout", n, 16384);
    check(tmo_flag_o == 1'b1, "R3 flag with reset", tmo_flag_o, 1);
    @(negedge clk_i);
    check(wdt_rst_o == 1'b0, "R3 single pulse", wdt_rst_o, 0);
    repeat (3) @(negedge clk_i);
    check(tmo_flag_o == 1'b1, "R5 flag sticky", tmo_flag_o, 1);
    clear_flag();
    check(tmo_flag_o == 1'b0, "R5 flag cleared", tmo_flag_o, 0);

    // random prescale/reload settings in watchdog mode
    for (int k = 0; k < 6; k++) begin
      sel = int'($urandom % 3);
      rl  = int'($urandom % 8);
      c = {sel[2:0], 5'b00101};
      wr_reg(1'b0, c);
      wr_reg(1'b1, rl[7:0]);
      feed(1'b1);
      check(ctrl_o == c, "R8 shadow applied", ctrl_o, c);
      check(count_o == rl[7:0], "R8 counter loaded", count_o, rl);
      wait_expiry(1'b1, n);
      check(n == exp_tmo(sel, rl), "R2 timeout", n, exp_tmo(sel, rl));
      check(tmo_flag_o, "R3 flag", tmo_flag_o, 1);
      @(negedge clk_i);
      check(!wdt_rst_o, "R3 one cycle", wdt_rst_o, 0);
      clear_flag();
    end

    // R9 disarm, R10 hold
    wr_reg(1'b0, 8'h05);
    feed(1'b1);
    wr_reg(1'b0, 8'h01);
    check(ctrl_o == 8'h01, "R9 direct write after feed", ctrl_o, 8'h01);
    snap = count_o; rs = rst_seen;
    repeat (3000) @(negedge clk_i);
    check(count_o == snap[7:0], "R10 counter held", count_o, snap);
    check(rst_seen == rs && !tmo_flag_o, "R10 no expiry", rst_seen - rs, 0);

    // R6 shadow lock
    wr_reg(1'b0, 8'h25);
    check(ctrl_o == 8'h01, "R6 write locked", ctrl_o, 8'h01);
    // R7 aborted then restarted pattern
    feed_byte(8'hA5, 1'b0); feed_byte(8'h33, 1'b0); feed_byte(8'h5A, 1'b0);
    check(ctrl_o == 8'h01, "R7 abort", ctrl_o, 8'h01);
    feed_byte(8'hA5, 1'b0); feed_byte(8'hA5, 1'b0); feed_byte(8'h5A, 1'b0);
    check(ctrl_o == 8'h25, "R7 restart", ctrl_o, 8'h25);

    // R4 timer mode
    wr_reg(1'b1, 8'd3);
    wr_reg(1'b0, 8'h04);
    check(ctrl_o == 8'h04, "R9 unlock write", ctrl_o, 8'h04);
    rs = rst_seen;
    feed(1'b1);
    check(!tmo_flag_o, "R5 flag cleared at feed", tmo_flag_o, 0);
    wait_expiry(1'b0, n);
    check(n == exp_tmo(0, 3), "R2/R4 timer timeout", n, exp_tmo(0, 3));
    repeat (2) @(negedge clk_i);
    check(rst_seen == rs, "R4 no reset in timer mode", rst_seen - rs, 0);

    // R11 run bit direct in timer mode
    wr_reg(1'b0, 8'h04);
    wr_reg(1'b0, 8'h00);
    check(ctrl_o == 8'h00, "R11 run cleared", ctrl_o, 8'h00);
    snap = count_o;
    repeat (500) @(negedge clk_i);
    check(count_o == snap[7:0], "R10 timer stopped", count_o, snap);
    wr_reg(1'b0, 8'hE5);
    check(ctrl_o == 8'h04, "R11 only run taken", ctrl_o, 8'h04);
    snap = count_o;
    repeat (40) @(negedge clk_i);
    check(count_o != snap[7:0], "R11 counting resumed", count_o, snap);

    done = 1'b1;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule